// File: doc/BRIEF.md
# Dual-Port Doorbell Interrupt Controller

The block holds four 16-bit doorbell registers: a request register and a mask register for each of two host sides, called primary and secondary. Each host has its own single-cycle register port (address, byte enables, write data, write strobe, read data), and both ports reach all four registers. A register changes only when ones are written to it. Each register has a set alias, where a 1 in the write data sets that bit, and a clear alias, where a 1 clears it. A 0 in the write data leaves the bit as it was. Byte enables limit a write to the selected bytes, so each register can also be used as two separate 8-bit groups.

Each side has one active-low interrupt output. It is low while any request bit on that side is 1 and the matching mask bit is 0. Software on one side can ring the other side's doorbell by setting a request bit. The receiving side acknowledges by clearing that bit, or masks the bit to silence it.

Top module: `doorbell_ctrl`

## Requirements
- R1: After reset both request registers read 16'h0000, both mask registers read 16'hFFFF, and both interrupt outputs are high.
- R2: Address bits [2:1] select the register: 0 is primary request, 1 is secondary request, 2 is primary mask and 3 is secondary mask. Address bit 0 selects the alias: 0 is the set alias and 1 is the clear alias.
- R3: A write to a set alias sets every enabled bit whose write-data bit is 1 and leaves every bit written with 0 unchanged. The new value is visible on the first cycle after the write.
- R4: A write to a clear alias clears every enabled bit whose write-data bit is 1 and leaves every bit written with 0 unchanged.
- R5: Byte enable bit 0 covers data bits [7:0] and byte enable bit 1 covers data bits [15:8]. Bytes whose enable is 0 are not changed.
- R6: In the same cycle, read data equals the current contents of the addressed register, whichever alias is addressed. A read never changes any register.
- R7: Both ports can set and clear all four registers, and both behave in the same way.
- R8: When both ports write the same register in one cycle, the new value is (old | set bits) & ~clear bits. A clear therefore wins over a set of the same bit.
- R9: The primary interrupt output is registered. In the cycle after any primary request bit is 1 while its primary mask bit is 0, the output is low; otherwise it is high.
- R10: The secondary interrupt output follows the same rule as R9, using the secondary request and secondary mask registers.
- R11: While both write strobes are low, no register changes, whatever the address, byte enables and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_addr_i | input | 3 | Primary port word address |
| pri_be_i | input | 2 | Primary port byte enables |
| pri_wdata_i | input | 16 | Primary port write data |
| pri_we_i | input | 1 | Primary port write strobe |
| pri_rdata_o | output | 16 | Primary port read data |
| sec_addr_i | input | 3 | Secondary port word address |
| sec_be_i | input | 2 | Secondary port byte enables |
| sec_wdata_i | input | 16 | Secondary port write data |
| sec_we_i | input | 1 | Secondary port write strobe |
| sec_rdata_o | output | 16 | Secondary port read data |
| pri_irq_no | output | 1 | Primary interrupt, active low |
| sec_irq_no | output | 1 | Secondary interrupt, active low |

## Verification
Two functions can fall in the same cycle. The first is both ports writing one register. The second is a register update that lands in the same cycle as the interrupt output is recomputed from the old register values. A directed step has one port set all bits while the other port clears a subset of them. The random phase also issues both strobes at once, with random addresses, so the two ports often collide on one register. Each result is judged against a bench model that merges set and clear per R8. The interrupt is expected one edge after the model's register state changes.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int unsigned NREG  = 4;
  localparam int unsigned NPORT = 2;
  localparam int unsigned SEL_W = $clog2(NREG);
  localparam int unsigned ADDR_W = SEL_W + 1;
  // register select values (address bits [ADDR_W-1:1])
  localparam int unsigned REG_PRI_REQ  = 0;
  localparam int unsigned REG_SEC_REQ  = 1;
  localparam int unsigned REG_PRI_MASK = 2;
  localparam int unsigned REG_SEC_MASK = 3;
endpackage

// File: rtl/db_port_dec.sv
module db_port_dec
  import db_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NBYTE-1:0]             be_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         we_i,
  output logic [NREG-1:0][DATA_W-1:0]  set_o,
  output logic [NREG-1:0][DATA_W-1:0]  clr_o
);
  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] wbits;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign bmask[b*8 +: 8] = {8{be_i[b]}};
  end

  assign wbits = wdata_i & bmask;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit      = we_i && (addr_i[ADDR_W-1:1] == SEL_W'(r));
    assign set_o[r] = (hit && !addr_i[0]) ? wbits : '0;
    assign clr_o[r] = (hit &&  addr_i[0]) ? wbits : '0;
  end
endmodule

// File: rtl/db_bit_reg.sv
module db_bit_reg #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= (q_o | set_i) & ~clr_i;  // clear dominates
  end
endmodule

// File: rtl/db_irq.sv
module db_irq #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] req_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~|(req_i & ~mask_i);
  end
endmodule

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import db_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        pri_addr_i,
  input  logic [NBYTE-1:0]  pri_be_i,
  input  logic [DATA_W-1:0] pri_wdata_i,
  input  logic              pri_we_i,
  output logic [DATA_W-1:0] pri_rdata_o,
  input  logic [2:0]        sec_addr_i,
  input  logic [NBYTE-1:0]  sec_be_i,
  input  logic [DATA_W-1:0] sec_wdata_i,
  input  logic              sec_we_i,
  output logic [DATA_W-1:0] sec_rdata_o,
  output logic              pri_irq_no,
  output logic              sec_irq_no
);
  logic [NPORT-1:0][ADDR_W-1:0] p_addr;
  logic [NPORT-1:0][NBYTE-1:0]  p_be;
  logic [NPORT-1:0][DATA_W-1:0] p_wdata;
  logic [NPORT-1:0]             p_we;
  logic [NPORT-1:0][NREG-1:0][DATA_W-1:0] p_set, p_clr;
  logic [NREG-1:0][DATA_W-1:0]  set_all, clr_all;
  logic [NREG-1:0][DATA_W-1:0]  reg_q;
  logic [NPORT-1:0]             irq_n;

  assign p_addr[0]  = pri_addr_i;
  assign p_addr[1]  = sec_addr_i;
  assign p_be[0]    = pri_be_i;
  assign p_be[1]    = sec_be_i;
  assign p_wdata[0] = pri_wdata_i;
  assign p_wdata[1] = sec_wdata_i;
  assign p_we[0]    = pri_we_i;
  assign p_we[1]    = sec_we_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    db_port_dec #(.DATA_W(DATA_W)) u_dec (
      .addr_i  (p_addr[p]),
      .be_i    (p_be[p]),
      .wdata_i (p_wdata[p]),
      .we_i    (p_we[p]),
      .set_o   (p_set[p]),
      .clr_o   (p_clr[p])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NPORT; p++) begin
      set_all = set_all | p_set[p];
      clr_all = clr_all | p_clr[p];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [DATA_W-1:0] RV =
      (r == REG_PRI_MASK || r == REG_SEC_MASK) ? {DATA_W{1'b1}} : '0;
    db_bit_reg #(.DATA_W(DATA_W), .RST_VAL(RV)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_all[r]),
      .clr_i  (clr_all[r]),
      .q_o    (reg_q[r])
    );
  end

  assign pri_rdata_o = reg_q[pri_addr_i[ADDR_W-1:1]];
  assign sec_rdata_o = reg_q[sec_addr_i[ADDR_W-1:1]];

  for (genvar s = 0; s < NPORT; s++) begin : g_irq
    localparam int unsigned RQ = (s == 0) ? REG_PRI_REQ  : REG_SEC_REQ;
    localparam int unsigned MK = (s == 0) ? REG_PRI_MASK : REG_SEC_MASK;
    db_irq #(.DATA_W(DATA_W)) u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (reg_q[RQ]),
      .mask_i (reg_q[MK]),
      .irq_no (irq_n[s])
    );
  end

  assign pri_irq_no = irq_n[0];
  assign sec_irq_no = irq_n[1];
endmodule

// File: rtl/db_chk.sv
module db_chk
  import db_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [2:0]                  pri_addr_i,
  input logic [NBYTE-1:0]            pri_be_i,
  input logic [DATA_W-1:0]           pri_wdata_i,
  input logic                        pri_we_i,
  input logic [2:0]                  sec_addr_i,
  input logic                        sec_we_i,
  input logic                        pri_irq_no,
  input logic                        sec_irq_no,
  input logic [NREG-1:0][DATA_W-1:0] reg_q
);
  logic [NREG*8-1:0] top_bytes;
  for (genvar r = 0; r < NREG; r++) begin : g_tb
    assign top_bytes[r*8 +: 8] = reg_q[r][DATA_W-1 -: 8];
  end

  logic full_be;
  logic sec_clr_same;
  assign full_be      = &pri_be_i;
  assign sec_clr_same = sec_we_i && sec_addr_i[0] &&
                        (sec_addr_i[2:1] == pri_addr_i[2:1]);

  // R9
  pri_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pri_irq_no == !$past(|(reg_q[REG_PRI_REQ] & ~reg_q[REG_PRI_MASK])));

  // R10
  sec_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sec_irq_no == !$past(|(reg_q[REG_SEC_REQ] & ~reg_q[REG_SEC_MASK])));

  // R11
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pri_we_i && !sec_we_i) |=> $stable(reg_q));

  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_we_i && pri_addr_i[0] && full_be)
      |=> (reg_q[$past(pri_addr_i[2:1])] & $past(pri_wdata_i)) == '0);

  // R3
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_we_i && !pri_addr_i[0] && full_be && !sec_clr_same)
      |=> (reg_q[$past(pri_addr_i[2:1])] & $past(pri_wdata_i)) == $past(pri_wdata_i));

  // R5
  byte_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_we_i && !sec_we_i && !pri_be_i[NBYTE-1]) |=> $stable(top_bytes));
endmodule

bind doorbell_ctrl db_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pri_addr_i  (pri_addr_i),
  .pri_be_i    (pri_be_i),
  .pri_wdata_i (pri_wdata_i),
  .pri_we_i    (pri_we_i),
  .sec_addr_i  (sec_addr_i),
  .sec_we_i    (sec_we_i),
  .pri_irq_no  (pri_irq_no),
  .sec_irq_no  (sec_irq_no),
  .reg_q       (reg_q)
);

// File: tb/sim_doorbell_ctrl.sv
`timescale 1ns/1ps
module sim_doorbell_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [2:0]  pa, sa;
  logic [1:0]  pbe, sbe;
  logic [15:0] pd, sd;
  logic        pwe, swe;
  logic [15:0] pr, sr;
  logic        pirq, sirq;

  doorbell_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pri_addr_i(pa), .pri_be_i(pbe), .pri_wdata_i(pd), .pri_we_i(pwe), .pri_rdata_o(pr),
    .sec_addr_i(sa), .sec_be_i(sbe), .sec_wdata_i(sd), .sec_we_i(swe), .sec_rdata_o(sr),
    .pri_irq_no(pirq), .sec_irq_no(sirq)
  );

  logic [15:0] m_reg [4];
  logic        e_pirq, e_sirq;
  int          total = 0, bad = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bmask(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // one access cycle on both ports, checked against the model
  task automatic step(string tag,
                      logic [2:0] a1, logic [1:0] b1, logic [15:0] d1, logic w1,
                      logic [2:0] a2, logic [1:0] b2, logic [15:0] d2, logic w2);
    logic [15:0] s [4];
    logic [15:0] c [4];
    @(negedge clk);
    pa = a1; pbe = b1; pd = d1; pwe = w1;
    sa = a2; sbe = b2; sd = d2; swe = w2;
    #1;
    chk(tag, pr, m_reg[a1[2:1]]);
    chk(tag, sr, m_reg[a2[2:1]]);
    chk("R9", {15'd0, pirq}, {15'd0, e_pirq});
    chk("R10", {15'd0, sirq}, {15'd0, e_sirq});
    for (int r = 0; r < 4; r++) begin s[r] = '0; c[r] = '0; end
    if (w1) begin
      if (a1[0]) c[a1[2:1]] |= d1 & bmask(b1);
      else       s[a1[2:1]] |= d1 & bmask(b1);
    end
    if (w2) begin
      if (a2[0]) c[a2[2:1]] |= d2 & bmask(b2);
      else       s[a2[2:1]] |= d2 & bmask(b2);
    end
    @(posedge clk);
    e_pirq = ~|(m_reg[0] & ~m_reg[2]);
    e_sirq = ~|(m_reg[1] & ~m_reg[3]);
    for (int r = 0; r < 4; r++) m_reg[r] = (m_reg[r] | s[r]) & ~c[r];
  endtask

  task automatic idle(string tag, logic [2:0] a1, logic [2:0] a2);
    step(tag, a1, 2'b11, 16'hFFFF, 1'b0, a2, 2'b11, 16'hFFFF, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    pa = '0; sa = '0; pbe = '0; sbe = '0; pd = '0; sd = '0; pwe = 1'b0; swe = 1'b0;
    m_reg[0] = 16'h0000; m_reg[1] = 16'h0000;
    m_reg[2] = 16'hFFFF; m_reg[3] = 16'hFFFF;
    e_pirq = 1'b1; e_sirq = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {15'd0, pirq}, 16'd1);
    chk("R1", {15'd0, sirq}, 16'd1);
    rst_n = 1'b1;

    // R1 / R2: reset contents visible at all eight aliases
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      pa = 3'(a); sa = 3'(7 - a);
      #1;
      chk("R1", pr, (a >= 4) ? 16'hFFFF : 16'h0000);
      chk("R2", sr, ((7 - a) >= 4) ? 16'hFFFF : 16'h0000);
    end

    // R3: primary sets primary request bits, masked so irq stays high
    step("R3", 3'd0, 2'b11, 16'h0005, 1'b1, 3'd4, 2'b11, 16'h0, 1'b0);
    idle("R6", 3'd1, 3'd0);
    // R7: secondary port unmasks primary bit 0 -> irq low later (R9)
    step("R7", 3'd0, 2'b11, 16'h0, 1'b0, 3'd5, 2'b11, 16'h0001, 1'b1);
    idle("R6", 3'd4, 3'd5);
    idle("R6", 3'd0, 3'd4);
    // R5: only low byte written
    step("R5", 3'd2, 2'b01, 16'hFFFF, 1'b1, 3'd0, 2'b11, 16'h0, 1'b0);
    idle("R5", 3'd2, 3'd3);
    // R8: same register, set all from primary, clear nibble from secondary
    step("R8", 3'd0, 2'b11, 16'hFFFF, 1'b1, 3'd1, 2'b11, 16'h00F0, 1'b1);
    idle("R8", 3'd0, 3'd1);
    // R4: clear alias
    step("R4", 3'd1, 2'b11, 16'h000F, 1'b1, 3'd0, 2'b11, 16'h0, 1'b0);
    idle("R4", 3'd0, 3'd1);
    // R11: strobes low, data present
    step("R11", 3'd1, 2'b11, 16'hFFFF, 1'b0, 3'd3, 2'b11, 16'hFFFF, 1'b0);
    idle("R11", 3'd1, 3'd3);
    // R10: secondary doorbell rung and unmasked
    step("R10", 3'd2, 2'b11, 16'h8000, 1'b1, 3'd7, 2'b10, 16'h8000, 1'b1);
    idle("R10", 3'd6, 3'd2);
    idle("R10", 3'd6, 3'd2);
    // R4: secondary acknowledges, irq returns high
    step("R4", 3'd0, 2'b11, 16'h0, 1'b0, 3'd3, 2'b11, 16'hFFFF, 1'b1);
    idle("R10", 3'd2, 3'd2);
    idle("R10", 3'd2, 3'd2);

    // random mix, both ports, frequent collisions
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      step("R7", r1[2:0], r1[4:3], r1[31:16], r1[5] | r1[6],
                 r2[2:0], r2[4:3], r2[31:16], r2[5] & r2[6]);
    end
    idle("R6", 3'd0, 3'd1);
    idle("R6", 3'd2, 3'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule